// File: doc/BRIEF.md
# Partitioned Table Control-Word Expander

This block sits in the fetch stage and turns a 32-bit compressed instruction into a 77-bit control word in a single registered step. An expand instruction carries six 4-bit index fields. Each field selects one entry from its own small table, and the tables each cover a fixed, uneven slice of the control word. The values read from the six tables are laid side by side to form the wide word. The 32-bit immediate does not pass through this block.

A table-load instruction rewrites one entry of one table at run time, so the compiler can retune the tables for each phase of a program. A load produces no control word. The instruction that follows a load already sees the new entry.

Instructions enter with a valid/ready pair. The control word leaves one cycle later, with its own valid flag. While the downstream stage stalls, the output word is held steady.

Top module: `ctrl_expander`

## Requirements
- R1: While reset is active and after it is released, `out_valid` is 0 and every entry of every table reads as zero. An expand instruction issued first after reset therefore produces a word of all zeros.
- R2: Bit 31 of the instruction selects the kind, with 0 meaning expand. In an expand instruction, the index for table t sits at bits [4t+3:4t] for t = 0..5, and bits 30..24 are ignored.
- R3: The control word is assembled from the six tables in this layout:
  - table 0 is 18 bits wide and fills bits [17:0];
  - table 1 is 8 bits wide and fills bits [25:18];
  - table 2 is 14 bits wide and fills bits [39:26];
  - table 3 is 10 bits wide and fills bits [49:40];
  - table 4 is 15 bits wide and fills bits [64:50];
  - table 5 is 12 bits wide and fills bits [76:65].
- R4: A table-load instruction has bit 31 = 1, the table number at bits [30:28], the entry number at bits [27:24] and the data at bits [17:0]. It writes exactly one entry, storing only the low bits of the data that fit the width of the target table.
- R5: An accepted table-load produces no output word: `out_valid` is 0 in the following cycle.
- R6: A table-load takes effect for the next instruction. An expand accepted in the cycle right after a load reads the new value.
- R7: A table-load whose table number is 6 or 7 changes no table.
- R8: An accepted expand instruction presents its word on `out_word`, with `out_valid` = 1, in the next cycle.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` = 1 and `out_ready` = 0, the outputs `out_valid` and `out_word` stay unchanged.
- R10: When the output can advance but no instruction is accepted, `out_valid` falls to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_instr | input | 32 | Compressed instruction |
| in_ready | output | 1 | The block accepts the offered instruction this cycle |
| out_valid | output | 1 | `out_word` holds an expanded control word |
| out_word | output | 77 | Expanded control word |
| out_ready | input | 1 | The downstream stage takes the word this cycle |

## Verification
The hardest case to reach from the ports is a load followed at once by an expand that reads the same entry. It gets harder still when a stall falls between the two, or when the load targets a table number that does not exist. The stimulus uses only four entry numbers for both loads and indices, so loads and the reads that follow them keep colliding. It mixes loads to all eight table numbers with random downstream stalls. A behavioural model recomputes the word from its own copy of the tables on every clock.

// File: rtl/ctrl_exp_pkg.sv
package ctrl_exp_pkg;
  localparam int NUM_TBL   = 6;
  localparam int IDX_W     = 4;
  localparam int DEPTH     = 1 << IDX_W;
  localparam int INSTR_W   = 32;
  localparam int WORD_W    = 77;
  localparam int LD_DATA_W = 18;
  localparam int TSEL_W    = 3;
  localparam int LOAD_BIT  = INSTR_W - 1;
  localparam int TSEL_LSB  = LOAD_BIT - TSEL_W;
  localparam int ENTRY_LSB = TSEL_LSB - IDX_W;

  // width of the control-word slice owned by table t
  function automatic int part_width(input int t);
    case (t)
      0: return 18;
      1: return 8;
      2: return 14;
      3: return 10;
      4: return 15;
      default: return 12;
    endcase
  endfunction

  // first control-word bit owned by table t
  function automatic int part_offset(input int t);
    int s;
    s = 0;
    for (int i = 0; i < t; i++) s += part_width(i);
    return s;
  endfunction
endpackage

// File: rtl/ctrl_exp_decode.sv
module ctrl_exp_decode
  import ctrl_exp_pkg::*;
(
  input  logic [INSTR_W-1:0]         instr,
  output logic                       is_load,
  output logic [TSEL_W-1:0]          tbl_sel,
  output logic [IDX_W-1:0]           wr_entry,
  output logic [LD_DATA_W-1:0]       ld_data,
  output logic [NUM_TBL*IDX_W-1:0]   idx_flat
);
  assign is_load  = instr[LOAD_BIT];
  assign tbl_sel  = instr[TSEL_LSB +: TSEL_W];
  assign wr_entry = instr[ENTRY_LSB +: IDX_W];
  assign ld_data  = instr[LD_DATA_W-1:0];
  assign idx_flat = instr[NUM_TBL*IDX_W-1:0];
endmodule

// File: rtl/ctrl_exp_table.sv
module ctrl_exp_table #(
  parameter int W     = 8,
  parameter int IDX_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // combinational read sees the contents before this cycle's write
  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/ctrl_exp_outreg.sv
module ctrl_exp_outreg #(
  parameter int WORD_W = 77
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expand_fire,
  input  logic              load_fire,
  input  logic              out_ready,
  input  logic [WORD_W-1:0] word_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (expand_fire) begin
      out_valid <= 1'b1;
      out_word  <= word_in;
    end else if (load_fire || out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctrl_expander.sv
module ctrl_expander
  import ctrl_exp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               in_ready,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_word,
  input  logic               out_ready
);
  logic                     is_load;
  logic [TSEL_W-1:0]        tbl_sel;
  logic [IDX_W-1:0]         wr_entry;
  logic [LD_DATA_W-1:0]     ld_data;
  logic [NUM_TBL*IDX_W-1:0] idx_flat;
  logic [WORD_W-1:0]        merged;

  // named events for the checker
  logic               accept;
  logic               load_fire;
  logic               expand_fire;
  logic [NUM_TBL-1:0] tbl_we;

  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;
  assign load_fire   = accept && is_load;
  assign expand_fire = accept && !is_load;

  ctrl_exp_decode u_dec (
    .instr    (in_instr),
    .is_load  (is_load),
    .tbl_sel  (tbl_sel),
    .wr_entry (wr_entry),
    .ld_data  (ld_data),
    .idx_flat (idx_flat)
  );

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    localparam int W   = part_width(t);
    localparam int OFF = part_offset(t);

    assign tbl_we[t] = load_fire && (tbl_sel == TSEL_W'(t));

    ctrl_exp_table #(.W(W), .IDX_W(IDX_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (tbl_we[t]),
      .wr_idx  (wr_entry),
      .wr_data (ld_data[W-1:0]),
      .rd_idx  (idx_flat[t*IDX_W +: IDX_W]),
      .rd_data (merged[OFF +: W])
    );
  end

  ctrl_exp_outreg #(.WORD_W(WORD_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .expand_fire (expand_fire),
    .load_fire   (load_fire),
    .out_ready   (out_ready),
    .word_in     (merged),
    .out_valid   (out_valid),
    .out_word    (out_word)
  );
endmodule

// File: rtl/ctrl_exp_chk.sv
module ctrl_exp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_instr,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [76:0] out_word,
  input logic        load_fire,
  input logic        expand_fire,
  input logic [5:0]  tbl_we
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tbl_we));

  // R4
  load_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire && (in_instr[30:28] < 3'd6) |-> $countones(tbl_we) == 1);

  // R7
  bad_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire && (in_instr[30:28] >= 3'd6) |-> tbl_we == '0);

  // R5
  load_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> !out_valid);

  // R8
  expand_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expand_fire |=> out_valid);

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && !in_valid |=> !out_valid);
endmodule

bind ctrl_expander ctrl_exp_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_instr    (in_instr),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_word    (out_word),
  .load_fire   (load_fire),
  .expand_fire (expand_fire),
  .tbl_we      (tbl_we)
);

// File: tb/ctrl_expander_bench.sv
module ctrl_expander_bench;
  localparam int PERIOD = 10;
  localparam int MAX_CYC = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic        in_ready;
  logic        out_valid;
  logic [76:0] out_word;
  logic        out_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ctrl_expander u_ctrl_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_ready(in_ready), .out_valid(out_valid), .out_word(out_word),
    .out_ready(out_ready)
  );

  always #(PERIOD/2) clk = ~clk;

  // reference model state
  int          wid [6] = '{18, 8, 14, 10, 15, 12};
  logic [17:0] mdl_tbl [6][16];
  bit          m_valid;
  logic [76:0] m_word;

  function automatic logic [76:0] build(input logic [31:0] ins);
    logic [76:0] w;
    int off;
    w = '0;
    off = 0;
    for (int t = 0; t < 6; t++) begin
      w = w | (77'(mdl_tbl[t][ins[4*t +: 4]]) << off);
      off += wid[t];
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 6; t++)
        for (int e = 0; e < 16; e++) mdl_tbl[t][e] = '0;
      m_valid = 0;
      m_word  = '0;
    end else begin
      if (in_valid && (!m_valid || out_ready)) begin
        if (in_instr[31]) begin
          if (in_instr[30:28] < 3'd6) begin
            int t;
            t = int'(in_instr[30:28]);
            mdl_tbl[t][in_instr[27:24]] = in_instr[17:0] & ((18'h1 << wid[t]) - 18'h1);
          end
          m_valid = 0;
        end else begin
          m_word  = build(in_instr);
          m_valid = 1;
        end
      end else if (out_ready) begin
        m_valid = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [76:0] act, input logic [76:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    check(out_valid == m_valid, "R5 R8 R10 out_valid", 77'(out_valid), 77'(m_valid));
    if (m_valid)
      check(out_word == m_word, "R2 R3 R4 R6 R7 out_word", out_word, m_word);
  endtask

  task automatic drive(input bit v, input logic [31:0] ins, input bit rdy);
    @(negedge clk);
    compare_outputs();
    in_valid  = v;
    in_instr  = ins;
    out_ready = rdy;
    #1;
    check(in_ready == (!m_valid || out_ready), "R9 in_ready", 77'(in_ready), 77'(!m_valid || out_ready));
  endtask

  function automatic logic [31:0] ld(input int t, input int e, input logic [17:0] d);
    return {1'b1, 3'(t), 4'(e), 6'h0, d};
  endfunction

  function automatic logic [31:0] ex(input int i0, input int i1, input int i2,
                                     input int i3, input int i4, input int i5);
    return {8'h5A & 8'h7F, 4'(i5), 4'(i4), 4'(i3), 4'(i2), 4'(i1), 4'(i0)};
  endfunction

  initial begin
    // R1: reset state
    #(PERIOD*2 + 2);
    check(out_valid == 1'b0, "R1 out_valid in reset", 77'(out_valid), 77'(0));
    check(in_ready == 1'b1, "R1 in_ready in reset", 77'(in_ready), 77'(1));
    @(negedge clk);
    rst_n = 1'b1;

    // R1: zero tables give a zero word
    drive(1, ex(0, 3, 7, 9, 12, 15), 1);
    drive(0, '0, 1);
    check(out_word == '0, "R1 zero word", out_word, '0);

    // R4 R3: fill every table at entry 5 with all ones, widths truncate
    for (int t = 0; t < 6; t++) drive(1, ld(t, 5, 18'h3FFFF), 1);
    drive(1, ex(5, 5, 5, 5, 5, 5), 1);
    drive(1, ex(5, 0, 0, 0, 0, 0), 1);
    drive(1, ex(0, 0, 0, 0, 0, 5), 1);
    // R6: load then expand back to back on the same entry
    drive(1, ld(2, 1, 18'h2AAAA), 1);
    drive(1, ex(0, 0, 1, 0, 0, 0), 1);
    // R7: table numbers 6 and 7 ignored
    drive(1, ld(6, 5, 18'h00000), 1);
    drive(1, ld(7, 1, 18'h00000), 1);
    drive(1, ex(5, 5, 1, 5, 5, 5), 1);
    // R9: stall holds the word
    drive(1, ex(0, 5, 0, 5, 0, 5), 0);
    drive(1, ex(5, 0, 5, 0, 5, 0), 0);
    drive(1, ex(5, 0, 5, 0, 5, 0), 0);
    drive(1, ex(5, 0, 5, 0, 5, 0), 1);
    // R10: drain
    drive(0, '0, 1);
    drive(0, '0, 1);

    // random mix with frequent collisions
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ins;
      if ($urandom % 10 < 4)
        ins = ld(int'($urandom % 8), int'($urandom % 4), 18'($urandom));
      else
        ins = {1'b0, 7'($urandom), 4'($urandom % 4), 4'($urandom % 4), 4'($urandom % 4),
               4'($urandom % 4), 4'($urandom % 4), 4'($urandom % 4)};
      drive(($urandom % 5) != 0, ins, ($urandom % 10) < 7);
    end
    drive(0, '0, 1);
    drive(0, '0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule